// File: doc/BRIEF.md
# Match-Compare System Timer with Synchronised Register Access

This block is a memory-mapped system timer. A free-running up-counter advances on a slow timer tick and wraps at its full width. A single match register is compared with the counter. On equality a pending flag is set, and that flag can drive a level interrupt. Software uses it both as a time source (it reads the counter) and as a one-shot event source (it programs a match value ahead of the current count).

The counter lives in a slow timer domain. That domain is modelled as a clock-enable tick derived from the bus clock. Because of this, bus access to the counter-side registers is not immediate. Reading the count needs an explicit snapshot request through the control register. Writing the count or the match value passes through a handshake that takes a fixed number of timer ticks. While a transfer is in flight, its busy bit is visible in an access-status register, and software polls that bit before it goes on.

The bus side is a plain register port: address, write strobe, write data and combinational read data.

Top module: `tick_match_timer`

## Requirements
- R1: After reset, the counter snapshot (offset 0x10), control (0x20), flags (0x14), interrupt enable (0x1C) and access status (0x24) all read 0, the match register (0x00) reads all ones, and `irq` is low. `rst_n` is synchronised internally and takes effect two clock edges after it rises.
- R2: The timer tick fires every TICK_DIV clock edges. The first tick is the TICK_DIV-th edge after the internal reset releases. The counter adds one on every tick while control bit 0 is set, holds while that bit is clear, and wraps modulo 2^CNT_W.
- R3: A write to control (0x20) with bit 1 set requests a snapshot and sets access-status bit 5. At the second tick after that write, bit 5 clears and offset 0x10 then holds the counter value from just before that tick.
- R4: A write to match (0x00) sets access-status bit 0. At the second tick after the write, the new value is applied and bit 0 clears. Offset 0x00 reads back the applied value.
- R5: A write to offset 0x10 sets access-status bit 4. At the second tick after the write, the counter is loaded with the written value, which overrides that tick's increment, and bit 4 clears.
- R6: A write to match or counter that arrives while that register's busy bit is set is ignored.
- R7: Control keeps bits 3:0 exactly as written and reads them back, so a read-modify-write of bit 0 leaves bits 3:1 unchanged.
- R8: Flag bit 0 (offset 0x14) sets on a tick, with the counter enabled, at which the counter value before the tick equals the match value.
- R9: Writing ones to flag bits 3:0 clears those bits, and zero bits leave them as they are. A set in the same cycle takes precedence over a clear.
- R10: `irq` is high exactly while flag bit 0 and interrupt-enable bit 0 are both set. Writing 0 to the enable masks `irq` and leaves the flag pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the timer tick is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt, enabled match flag pending |

## Verification
The bench builds the timer with CNT_W=8, TICK_DIV=3 and SYNC_TICKS=2. The narrow counter makes wrap-around reachable within a few dozen cycles. The short tick divider lets the bench sweep snapshot requests across every phase of the tick. With these values the bench computes every expected value from the edge index of each write: busy-clear edges, snapshot values and flag-set edges. It also sweeps several match values, including ones whose approach crosses the counter wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register byte offsets
  localparam logic [7:0] OFF_MATCH = 8'h00;
  localparam logic [7:0] OFF_COUNT = 8'h10;
  localparam logic [7:0] OFF_FLAGS = 8'h14;
  localparam logic [7:0] OFF_IEN   = 8'h1C;
  localparam logic [7:0] OFF_CTRL  = 8'h20;
  localparam logic [7:0] OFF_SYNC  = 8'h24;

  // access-status bit positions
  localparam int AS_MATCH_BIT = 0;
  localparam int AS_CWR_BIT   = 4;
  localparam int AS_CRD_BIT   = 5;

  // control fields
  localparam int CTRL_W        = 4;
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SNAP_BIT = 1;

  localparam int FLAG_W = 4;

  // handshake channel indices
  localparam int CH_MATCH = 0;
  localparam int CH_CWR   = 1;
  localparam int CH_CRD   = 2;
  localparam int NCH      = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_FLAGS,
    SEL_IEN,
    SEL_CTRL,
    SEL_SYNC
  } reg_sel_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(DIV);
      logic [DW-1:0] div_q, div_d;

      assign tick = (div_q == DW'(DIV - 1));

      always_comb begin
        div_d = tick ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end

      // R2
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan #(
  parameter int SYNC_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic req,
  output logic busy,
  output logic accept,
  output logic fire
);
  localparam int CW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy   = busy_q;
  assign accept = req & ~busy_q;
  assign fire   = busy_q & tick & (cnt_q == CW'(SYNC_TICKS - 1));

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && tick) begin
      if (fire) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R3
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(tick));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> busy_q);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W  = 32,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              load,
  input  logic [CNT_W-1:0]  load_val,
  input  logic [CNT_W-1:0]  match_val,
  input  logic [FLAG_W-1:0] clr_mask,
  output logic [FLAG_W-1:0] flags,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0]  count_q, count_d;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic              hit;

  assign count = count_q;
  assign flags = flag_q;
  assign hit   = tick & run & (count_q == match_val);

  always_comb begin
    count_d = count_q;
    if (load)             count_d = load_val;
    else if (tick && run) count_d = count_q + 1'b1;
  end

  always_comb begin
    flag_d    = flag_q & ~clr_mask;
    flag_d[0] = flag_d[0] | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      flag_q  <= '0;
    end else begin
      count_q <= count_d;
      flag_q  <= flag_d;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !load) |=> (count_q == $past(count_q) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(tick && run)) |=> $stable(count_q));

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[0]) |-> $past(tick && run && (count_q == match_val)));
endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int TICK_DIV   = 16,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // address decode
  reg_sel_e sel;
  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_MATCH): sel = SEL_MATCH;
      ADDR_W'(OFF_COUNT): sel = SEL_COUNT;
      ADDR_W'(OFF_FLAGS): sel = SEL_FLAGS;
      ADDR_W'(OFF_IEN):   sel = SEL_IEN;
      ADDR_W'(OFF_CTRL):  sel = SEL_CTRL;
      ADDR_W'(OFF_SYNC):  sel = SEL_SYNC;
      default:            sel = SEL_NONE;
    endcase
  end

  logic wr_match, wr_count, wr_flags, wr_ien, wr_ctrl;
  assign wr_match = bus_we && (sel == SEL_MATCH);
  assign wr_count = bus_we && (sel == SEL_COUNT);
  assign wr_flags = bus_we && (sel == SEL_FLAGS);
  assign wr_ien   = bus_we && (sel == SEL_IEN);
  assign wr_ctrl  = bus_we && (sel == SEL_CTRL);

  // timer-domain clock enable
  logic tick;
  tmr_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_i),
    .tick (tick)
  );

  // handshake channels
  logic [NCH-1:0] ch_req, ch_busy, ch_accept, ch_fire;
  assign ch_req[CH_MATCH] = wr_match;
  assign ch_req[CH_CWR]   = wr_count;
  assign ch_req[CH_CRD]   = wr_ctrl && bus_wdata[CTRL_SNAP_BIT];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tmr_xfer_chan #(.SYNC_TICKS(SYNC_TICKS)) u_chan (
      .clk   (clk),
      .rst_n (rst_i),
      .tick  (tick),
      .req   (ch_req[c]),
      .busy  (ch_busy[c]),
      .accept(ch_accept[c]),
      .fire  (ch_fire[c])
    );
  end

  // bus-side registers
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ien_q, ien_d;
  logic [CNT_W-1:0]  pend_match_q, pend_match_d;
  logic [CNT_W-1:0]  pend_count_q, pend_count_d;
  logic [CNT_W-1:0]  match_q, match_d;
  logic [CNT_W-1:0]  snap_q, snap_d;
  logic [CNT_W-1:0]  count;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] clr_mask;

  assign clr_mask = wr_flags ? bus_wdata[FLAG_W-1:0] : '0;

  always_comb begin
    ctrl_d       = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    ien_d        = wr_ien  ? bus_wdata[0]          : ien_q;
    pend_match_d = ch_accept[CH_MATCH] ? bus_wdata[CNT_W-1:0] : pend_match_q;
    pend_count_d = ch_accept[CH_CWR]   ? bus_wdata[CNT_W-1:0] : pend_count_q;
    match_d      = ch_fire[CH_MATCH]   ? pend_match_q         : match_q;
    snap_d       = ch_fire[CH_CRD]     ? count                : snap_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q       <= '0;
      ien_q        <= 1'b0;
      pend_match_q <= '0;
      pend_count_q <= '0;
      match_q      <= '1;
      snap_q       <= '0;
    end else begin
      ctrl_q       <= ctrl_d;
      ien_q        <= ien_d;
      pend_match_q <= pend_match_d;
      pend_count_q <= pend_count_d;
      match_q      <= match_d;
      snap_q       <= snap_d;
    end
  end

  tmr_count_core #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (tick),
    .run      (ctrl_q[CTRL_RUN_BIT]),
    .load     (ch_fire[CH_CWR]),
    .load_val (pend_count_q),
    .match_val(match_q),
    .clr_mask (clr_mask),
    .flags    (flags),
    .count    (count)
  );

  assign irq = flags[0] & ien_q;

  // read-back
  logic [DATA_W-1:0] sync_word;
  always_comb begin
    sync_word               = '0;
    sync_word[AS_MATCH_BIT] = ch_busy[CH_MATCH];
    sync_word[AS_CWR_BIT]   = ch_busy[CH_CWR];
    sync_word[AS_CRD_BIT]   = ch_busy[CH_CRD];
  end

  always_comb begin
    case (sel)
      SEL_MATCH: bus_rdata = DATA_W'(match_q);
      SEL_COUNT: bus_rdata = DATA_W'(snap_q);
      SEL_FLAGS: bus_rdata = DATA_W'(flags);
      SEL_IEN:   bus_rdata = DATA_W'(ien_q);
      SEL_CTRL:  bus_rdata = DATA_W'(ctrl_q);
      SEL_SYNC:  bus_rdata = sync_word;
      default:   bus_rdata = '0;
    endcase
  end

  // R4
  match_apply_chk: assert property (@(posedge clk) disable iff (!rst_i)
    !$stable(match_q) |-> $past(ch_busy[CH_MATCH] && tick));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq) |-> (ien_q && flags[0]));
endmodule

// File: tb/sim_tick_match_timer.sv
module sim_tick_match_timer;
  localparam int CW = 8;
  localparam int DV = 3;
  localparam int ST = 2;
  localparam logic [7:0] A_MATCH = 8'h00, A_COUNT = 8'h10, A_FLAGS = 8'h14,
                         A_IEN = 8'h1C, A_CTRL = 8'h20, A_SYNC = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int ecnt = 0;
  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  tick_match_timer #(.DATA_W(32), .ADDR_W(8), .CNT_W(CW), .TICK_DIV(DV),
                     .SYNC_TICKS(ST)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq));

  function automatic bit is_tk(int e);
    return (e > 2) && (((e - 2) % DV) == 0);
  endfunction

  function automatic int ticks_in(int a, int b);
    int n = 0;
    for (int e = a + 1; e <= b; e++) if (is_tk(e)) n++;
    return n;
  endfunction

  function automatic int nth_tick(int a, int n);
    int e = a;
    int k = 0;
    while (k < n) begin
      e++;
      if (is_tk(e)) k++;
    end
    return e;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_clr(int bitpos, output int e);
    logic [31:0] v;
    e = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      rd(A_SYNC, v);
      if (!v[bitpos]) begin
        e = ecnt;
        return;
      end
    end
  endtask

  task automatic snap(logic [31:0] cv, output int f, output logic [31:0] v);
    int w;
    logic [31:0] s;
    wr(A_CTRL, cv | 32'h2);
    w = ecnt;
    rd(A_SYNC, s);
    chk("R3 snapshot busy set", {31'b0, s[5]}, 32'h1);
    wait_clr(5, f);
    chk("R3 snapshot busy clear edge", f, nth_tick(w, ST));
    rd(A_COUNT, v);
  endtask

  initial begin
    logic [31:0] v;
    int w0, wd, wc, wm, f, fc, fm, fe;
    logic [7:0] mv [5];
    mv[0] = 8'h00; mv[1] = 8'h07; mv[2] = 8'h80; mv[3] = 8'hFF; mv[4] = 8'h40;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_COUNT, v); chk("R1 count", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(A_FLAGS, v); chk("R1 flags", v, 0);
    rd(A_IEN, v);   chk("R1 ien", v, 0);
    rd(A_SYNC, v);  chk("R1 access", v, 0);
    rd(A_MATCH, v); chk("R1 match", v, 32'hFF);
    chk("R1 irq", {31'b0, irq}, 0);

    // R7 control storage and read-modify-write
    wr(A_CTRL, 32'hC);
    rd(A_CTRL, v); chk("R7 ctrl store", v, 32'hC);
    rd(A_CTRL, v);
    wr(A_CTRL, v | 32'h1);
    w0 = ecnt;
    rd(A_CTRL, v); chk("R7 ctrl rmw", v, 32'hD);

    // R3 snapshots swept over tick phase, R2 counting
    for (int g = 0; g < 6; g++) begin
      repeat (g) @(negedge clk);
      snap(32'hD, f, v);
      chk("R3 R2 snapshot value", v, 32'(ticks_in(w0, f - 1) & 8'hFF));
    end
    rd(A_CTRL, v); chk("R7 ctrl after snapshots", v, 32'hF);

    // R2 hold while disabled
    wr(A_CTRL, 32'hC);
    wd = ecnt;
    repeat (10) @(negedge clk);
    snap(32'hC, f, v);
    chk("R2 hold value", v, 32'(ticks_in(w0, wd) & 8'hFF));
    repeat (10) @(negedge clk);
    snap(32'hC, f, v);
    chk("R2 hold again", v, 32'(ticks_in(w0, wd) & 8'hFF));

    // R5 counter write with wrap (R2)
    wr(A_CTRL, 32'h1);
    wr(A_COUNT, 32'hFC);
    wc = ecnt;
    rd(A_SYNC, v); chk("R5 count busy set", {31'b0, v[4]}, 1);
    wait_clr(4, fc);
    chk("R5 count busy clear edge", fc, nth_tick(wc, ST));
    repeat (20) @(negedge clk);
    snap(32'h1, f, v);
    chk("R5 R2 loaded and wrapped", v, 32'((8'hFC + ticks_in(fc, f - 1)) & 8'hFF));

    // R4 match write and R6 ignored second write
    wr(A_MATCH, 32'h40);
    wm = ecnt;
    rd(A_SYNC, v); chk("R4 match busy set", {31'b0, v[0]}, 1);
    wr(A_MATCH, 32'h41);
    wait_clr(0, fm);
    chk("R4 match busy clear edge", fm, nth_tick(wm, ST));
    rd(A_MATCH, v); chk("R6 match write while busy ignored", v, 32'h40);

    wr(A_COUNT, 32'h10);
    wr(A_COUNT, 32'h90);
    wait_clr(4, fc);
    snap(32'h1, f, v);
    chk("R6 count write while busy ignored", v, 32'((8'h10 + ticks_in(fc, f - 1)) & 8'hFF));

    // R8 R9 R10 match sweep
    wr(A_IEN, 32'h1);
    for (int i = 0; i < 5; i++) begin
      wr(A_MATCH, {24'b0, mv[i]});
      wait_clr(0, fm);
      wr(A_COUNT, {24'b0, mv[i] - 8'd5});
      wait_clr(4, fc);
      wr(A_FLAGS, 32'hF);
      rd(A_FLAGS, v); chk("R9 clear all", v, 0);
      chk("R10 irq low after clear", {31'b0, irq}, 0);
      fe = -1;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        rd(A_FLAGS, v);
        if (v[0]) begin
          fe = ecnt;
          break;
        end
      end
      chk("R8 flag set edge", fe, nth_tick(fc, 6));
      chk("R10 irq high", {31'b0, irq}, 1);
      wr(A_FLAGS, 32'h0);
      rd(A_FLAGS, v); chk("R9 zero write keeps flag", v, 1);
      wr(A_IEN, 32'h0);
      chk("R10 irq masked", {31'b0, irq}, 0);
      rd(A_FLAGS, v); chk("R10 flag kept while masked", v, 1);
      wr(A_IEN, 32'h1);
      chk("R10 irq unmasked", {31'b0, irq}, 1);
      wr(A_FLAGS, 32'h1);
      rd(A_FLAGS, v); chk("R9 single clear", v, 0);
      chk("R10 irq after single clear", {31'b0, irq}, 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog (R1 run completion) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule